// File: doc/BRIEF.md
# Hierarchical Latched Interrupt Status Register

This block collects the top-level interrupt picture of a multi-channel power controller into a single 8-bit status word. Its lower four bits are sticky flags. Four global sources set them with single-cycle pulses:

- over-temperature shutdown
- over-temperature warning
- a reset or startup event
- completion of a load-current measurement

Each flag stays set until the host clears it by writing a one to its position. The upper four bits are live summaries of four per-channel interrupt registers. These registers arrive as 8-bit inputs. A summary bit reads 1 whenever its channel register is nonzero, and it drops as soon as that register returns to zero.

A small register bus reads the status word and clears its bits. The same bus reads and writes an interrupt mask and reads back the live thermal inputs. A level interrupt output is asserted whenever any status bit is set while its mask bit is set.

The block serves two further roles:

- While the shutdown flag is latched, it forces every converter-enable request to zero.
- When a software reset request or an undervoltage event arrives, it issues a one-cycle register-reset pulse to the rest of the register file. The reset-event flag is set after that pulse.

Top module: `irq_status_hub`

## Requirements
- R1: After synchronous reset the status word reads 0x00, the mask reads 0xFF, `irq_o` is 0 and `regfile_rst_o` is 0.
- R2: Status bit positions are fixed: bit 3 shutdown, bit 2 warning, bit 1 reset event, bit 0 measurement ready. A one-cycle pulse on the matching input (`startup_done` for bit 1) makes the bit read 1 from the next cycle, and the bit holds until cleared.
- R3: A write to address 0 clears each of bits 3..0 whose write-data bit is 1, from the next cycle on. Write-data bits that are 0 leave the status unchanged.
- R4: Status bits 7, 6, 5 and 4 read 1 exactly while channel 3, 2, 1 or 0 respectively has a nonzero register. Channel n occupies `ch_irq_regs[8n+7:8n]`. Writes to bits 7..4 have no effect.
- R5: When a set pulse and a write-one clear hit the same latched bit in one cycle, the bit reads 1 afterwards.
- R6: A cycle with `sw_rst_req` or `uvlo_evt` high is followed by exactly one cycle with `regfile_rst_o` high. Status bit 1 is still 0 during that cycle and reads 1 in the cycle after it. `startup_done` sets bit 1 directly, with no pulse.
- R7: The register-reset pulse returns the mask to 0xFF and leaves the latched status bits unchanged.
- R8: The mask register is read and written at address 1. `irq_o` is 1 exactly when (status AND mask) is nonzero. Masking never alters the stored status.
- R9: While status bit 3 is 1, `conv_en_o` is all zeros. Otherwise `conv_en_o` equals `conv_en_req`.
- R10: `live_therm_o` equals {`raw_warn`, `raw_sd`}. Address 2 reads {6'b0, `raw_warn`, `raw_sd`} and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 status, 1 mask, 2 live thermal, 3 reserved |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| evt_tsd | input | 1 | Shutdown event pulse |
| evt_twarn | input | 1 | Warning event pulse |
| evt_meas_done | input | 1 | Measurement-complete pulse |
| startup_done | input | 1 | Startup-complete pulse |
| uvlo_evt | input | 1 | Supply undervoltage pulse |
| sw_rst_req | input | 1 | Host software reset request |
| ch_irq_regs | input | 32 | Four 8-bit per-channel interrupt registers, channel 0 in the low byte |
| raw_sd | input | 1 | Live shutdown comparator level |
| raw_warn | input | 1 | Live warning comparator level |
| live_therm_o | output | 2 | Live thermal status {warn, shutdown} |
| conv_en_req | input | 4 | Converter enable requests |
| conv_en_o | output | 4 | Gated converter enables |
| regfile_rst_o | output | 1 | One-cycle register-file reset pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: four channels of 8 bits and four converters. Because the status and mask are only eight bits wide, the bench sweeps the whole space:

- all 16 latched-bit set patterns
- all 16 clear patterns against a full status word
- all 256 mask values against a mixed status word

Each result is compared with a value computed bit-wise in the bench. With four channels, every channel can also be stepped through zero, single-bit and full register values.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int EVT_W     = 4;
    localparam int BIT_MEAS  = 0;
    localparam int BIT_RSTEV = 1;
    localparam int BIT_TWARN = 2;
    localparam int BIT_TSD   = 3;

    typedef enum logic [1:0] {
        ADDR_STATUS = 2'd0,
        ADDR_MASK   = 2'd1,
        ADDR_LIVE   = 2'd2,
        ADDR_RSVD   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic tsd;
        logic twarn;
        logic rstev;
        logic meas;
    } evt_vec_t;

    typedef struct packed {
        logic      sel;
        logic      wr;
        reg_addr_e addr;
    } bus_ctl_t;

    function automatic logic is_write(bus_ctl_t c, reg_addr_e a);
        return c.sel && c.wr && (c.addr == a);
    endfunction

    function automatic logic [7:0] live_word(logic warn, logic sd);
        return {6'b0, warn, sd};
    endfunction

endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                q_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                q_o[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_rst_seq.sv
module irq_rst_seq (
    input  logic clk,
    input  logic rst,
    input  logic startup_done,
    input  logic uvlo_evt,
    input  logic sw_rst_req,
    output logic regfile_rst_o,
    output logic rstev_set_o
);
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= uvlo_evt | sw_rst_req;
        end
    end

    assign regfile_rst_o = pulse_q;
    assign rstev_set_o   = startup_done | pulse_q;
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 8
) (
    input  logic [NUM_CH*CH_W-1:0] regs_i,
    output logic [NUM_CH-1:0]      pend_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign pend_o[c] = |regs_i[c*CH_W +: CH_W];
    end
endmodule

// File: rtl/irq_conv_gate.sv
module irq_conv_gate #(
    parameter int NUM_CONV = 4
) (
    input  logic                shut_i,
    input  logic [NUM_CONV-1:0] req_i,
    output logic [NUM_CONV-1:0] en_o
);
    for (genvar k = 0; k < NUM_CONV; k++) begin : g_conv
        assign en_o[k] = req_i[k] & ~shut_i;
    end
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int CH_W     = 8,
    parameter int NUM_CONV = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                bus_sel,
    input  logic                                bus_wr,
    input  logic [1:0]                          bus_addr,
    input  logic [NUM_CH+irq_hub_pkg::EVT_W-1:0] bus_wdata,
    output logic [NUM_CH+irq_hub_pkg::EVT_W-1:0] bus_rdata,
    input  logic                                evt_tsd,
    input  logic                                evt_twarn,
    input  logic                                evt_meas_done,
    input  logic                                startup_done,
    input  logic                                uvlo_evt,
    input  logic                                sw_rst_req,
    input  logic [NUM_CH*CH_W-1:0]              ch_irq_regs,
    input  logic                                raw_sd,
    input  logic                                raw_warn,
    output logic [1:0]                          live_therm_o,
    input  logic [NUM_CONV-1:0]                 conv_en_req,
    output logic [NUM_CONV-1:0]                 conv_en_o,
    output logic                                regfile_rst_o,
    output logic                                irq_o
);
    localparam int STAT_W = NUM_CH + EVT_W;

    bus_ctl_t              ctl;
    evt_vec_t              evt_set;
    evt_vec_t              evt_clr;
    evt_vec_t              evt_q;
    logic [NUM_CH-1:0]     pend;
    logic [STAT_W-1:0]     stat_vec;
    logic [STAT_W-1:0]     mask_q;
    logic                  rstev_set;

    assign ctl = '{sel: bus_sel, wr: bus_wr, addr: reg_addr_e'(bus_addr)};

    irq_rst_seq u_rst_seq (
        .clk          (clk),
        .rst          (rst),
        .startup_done (startup_done),
        .uvlo_evt     (uvlo_evt),
        .sw_rst_req   (sw_rst_req),
        .regfile_rst_o(regfile_rst_o),
        .rstev_set_o  (rstev_set)
    );

    assign evt_set = '{tsd: evt_tsd, twarn: evt_twarn, rstev: rstev_set, meas: evt_meas_done};

    always_comb begin
        evt_clr = '0;
        if (is_write(ctl, ADDR_STATUS)) begin
            evt_clr = evt_vec_t'(bus_wdata[EVT_W-1:0]);
        end
    end

    irq_evt_latch #(.W(EVT_W)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .set_i(evt_set),
        .clr_i(evt_clr),
        .q_o  (evt_q)
    );

    irq_summary #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_summary (
        .regs_i(ch_irq_regs),
        .pend_o(pend)
    );

    assign stat_vec = {pend, evt_q};

    always_ff @(posedge clk) begin
        if (rst || regfile_rst_o) begin
            mask_q <= '1;
        end else if (is_write(ctl, ADDR_MASK)) begin
            mask_q <= bus_wdata;
        end
    end

    assign irq_o = |(stat_vec & mask_q);

    irq_conv_gate #(.NUM_CONV(NUM_CONV)) u_gate (
        .shut_i(evt_q.tsd),
        .req_i (conv_en_req),
        .en_o  (conv_en_o)
    );

    assign live_therm_o = {raw_warn, raw_sd};

    always_comb begin
        unique case (ctl.addr)
            ADDR_STATUS: bus_rdata = stat_vec;
            ADDR_MASK:   bus_rdata = mask_q;
            ADDR_LIVE:   bus_rdata = STAT_W'(live_word(raw_warn, raw_sd));
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_status_hub_chk.sv
module irq_status_hub_chk #(
    parameter int NUM_CH   = 4,
    parameter int CH_W     = 8,
    parameter int NUM_CONV = 4,
    parameter int STAT_W   = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_sel,
    input logic                     bus_wr,
    input logic [1:0]               bus_addr,
    input logic [STAT_W-1:0]        bus_wdata,
    input logic                     evt_tsd,
    input logic                     evt_twarn,
    input logic                     evt_meas_done,
    input logic                     uvlo_evt,
    input logic                     sw_rst_req,
    input logic [NUM_CH*CH_W-1:0]   ch_irq_regs,
    input logic [NUM_CONV-1:0]      conv_en_o,
    input logic                     regfile_rst_o,
    input logic                     irq_o,
    input logic [STAT_W-1:0]        stat_q,
    input logic [STAT_W-1:0]        mask_q
);
    AST_TSD_LATCH: assert property (@(posedge clk) disable iff (rst)
        evt_tsd |=> stat_q[3]); // R2
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 2'd0 && bus_wdata[2] && !evt_twarn) |=> !stat_q[2]); // R3
    AST_SUMMARY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ch_irq_regs[CH_W-1:0] == '0) |-> !stat_q[4]); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        evt_meas_done |=> stat_q[0]); // R5
    AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
        (sw_rst_req || uvlo_evt) |=> regfile_rst_o); // R6
    AST_RSTEV_AFTER: assert property (@(posedge clk) disable iff (rst)
        regfile_rst_o |=> stat_q[1]); // R6
    AST_MASK_RESTORE: assert property (@(posedge clk) disable iff (rst)
        regfile_rst_o |=> (mask_q == '1)); // R7
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (stat_q[3] && mask_q[3]) |-> irq_o); // R8
    AST_CONV_OFF: assert property (@(posedge clk) disable iff (rst)
        stat_q[3] |-> (conv_en_o == '0)); // R9
endmodule

bind irq_status_hub irq_status_hub_chk #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .NUM_CONV(NUM_CONV), .STAT_W(STAT_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt_tsd(evt_tsd),
    .evt_twarn(evt_twarn), .evt_meas_done(evt_meas_done),
    .uvlo_evt(uvlo_evt), .sw_rst_req(sw_rst_req), .ch_irq_regs(ch_irq_regs),
    .conv_en_o(conv_en_o), .regfile_rst_o(regfile_rst_o), .irq_o(irq_o),
    .stat_q(stat_vec), .mask_q(mask_q)
);

// File: tb/sim_irq_status_hub.sv
`timescale 1ns/1ps
module sim_irq_status_hub;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 0, bus_wr = 0;
    logic [1:0]  bus_addr = 0;
    logic [7:0]  bus_wdata = 0;
    logic [7:0]  bus_rdata;
    logic        evt_tsd = 0, evt_twarn = 0, evt_meas_done = 0;
    logic        startup_done = 0, uvlo_evt = 0, sw_rst_req = 0;
    logic [31:0] ch_irq_regs = 0;
    logic        raw_sd = 0, raw_warn = 0;
    logic [1:0]  live_therm_o;
    logic [3:0]  conv_en_req = 4'hF;
    logic [3:0]  conv_en_o;
    logic        regfile_rst_o, irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_status_hub u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_sel = 1; bus_wr = 0;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_sel = 1; bus_wr = 1;
        step();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic pulse(input logic [3:0] p);
        evt_tsd = p[3]; evt_twarn = p[2]; startup_done = p[1]; evt_meas_done = p[0];
        step();
        evt_tsd = 0; evt_twarn = 0; startup_done = 0; evt_meas_done = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        step(); step();
        rst = 0;
        step();
        // R1 reset state
        rd(2'd0, d); check("R1 status", d, 8'h00);
        rd(2'd1, d); check("R1 mask", d, 8'hFF);
        check("R1 irq", irq_o, 0);
        check("R1 regfile_rst", regfile_rst_o, 0);
        check("R9 ungated", conv_en_o, 4'hF);

        // R2 / R3 / R8 / R9 sweep of all set patterns
        for (int p = 0; p < 16; p++) begin
            pulse(p[3:0]);
            rd(2'd0, d); check("R2 set", d, {4'h0, p[3:0]});
            step();
            rd(2'd0, d); check("R2 hold", d, {4'h0, p[3:0]});
            check("R8 irq", irq_o, (p != 0));
            check("R9 gate", conv_en_o, p[3] ? 4'h0 : 4'hF);
            wr(2'd0, 8'h00);
            rd(2'd0, d); check("R3 zero write", d, {4'h0, p[3:0]});
            wr(2'd0, 8'h0F);
            rd(2'd0, d); check("R3 clear", d, 8'h00);
        end

        // R3 / R4 clear patterns against full status
        for (int c = 0; c < 16; c++) begin
            pulse(4'hF);
            wr(2'd0, {4'hF, c[3:0]});
            rd(2'd0, d); check("R3 partial clear", d, {4'h0, ~c[3:0]});
            wr(2'd0, 8'h0F);
        end

        // R5 set wins over clear
        for (int b = 0; b < 4; b++) begin
            bus_addr = 0; bus_wdata = 8'h0F; bus_sel = 1; bus_wr = 1;
            pulse(4'(1 << b));
            bus_sel = 0; bus_wr = 0;
            rd(2'd0, d); check("R5 set wins", d, 8'(1 << b));
            wr(2'd0, 8'h0F);
        end

        // R4 summary bits
        for (int ch = 0; ch < 4; ch++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] v;
                v = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h80 : 8'hFF;
                ch_irq_regs = 32'(v) << (8 * ch);
                rd(2'd0, d); check("R4 summary", d, (v != 0) ? 8'(16 << ch) : 8'h00);
            end
        end
        ch_irq_regs = 32'hFFFF_FFFF;
        wr(2'd0, 8'hF0);
        rd(2'd0, d); check("R4 write ignored", d, 8'hF0);
        ch_irq_regs = 0;
        rd(2'd0, d); check("R4 auto drop", d, 8'h00);

        // R6 / R7 reset-event causes
        for (int s = 0; s < 2; s++) begin
            pulse(4'h8);
            wr(2'd1, 8'h0F);
            if (s == 0) sw_rst_req = 1; else uvlo_evt = 1;
            step();
            sw_rst_req = 0; uvlo_evt = 0;
            check("R6 pulse high", regfile_rst_o, 1);
            rd(2'd0, d); check("R6 bit1 not yet", d[1], 0);
            step();
            check("R6 pulse one cycle", regfile_rst_o, 0);
            rd(2'd0, d); check("R6 bit1 set", d, 8'h0A);
            check("R7 latched kept", d[3], 1);
            rd(2'd1, d); check("R7 mask restored", d, 8'hFF);
            wr(2'd0, 8'h0F);
        end
        pulse(4'h2);
        check("R6 startup no pulse", regfile_rst_o, 0);
        rd(2'd0, d); check("R6 startup sets", d, 8'h02);
        wr(2'd0, 8'h0F);

        // R8 full mask sweep
        pulse(4'hF);
        ch_irq_regs = 32'h0011_0022;
        for (int m = 0; m < 256; m++) begin
            wr(2'd1, m[7:0]);
            check("R8 irq mask", irq_o, ((8'h5F & m[7:0]) != 0));
            rd(2'd1, d); check("R8 mask read", d, m[7:0]);
        end
        rd(2'd0, d); check("R8 status untouched", d, 8'h5F);
        ch_irq_regs = 0;
        wr(2'd0, 8'h0F);

        // R10 live thermal
        for (int w = 0; w < 4; w++) begin
            raw_sd = w[0]; raw_warn = w[1];
            #1 check("R10 live out", live_therm_o, w[1:0]);
            rd(2'd2, d); check("R10 live read", d, {6'b0, w[1:0]});
        end
        rd(2'd3, d); check("R10 reserved", d, 8'h00);

        finish_run();
    end
endmodule